// File: doc/BRIEF.md
# Memory Bit Read-Modify-Write Unit

This block runs one bit operation on a byte held in external memory. A request carries a base address, a signed 16-bit displacement, a 3-bit bit number and a 2-bit operation code. The unit adds the sign-extended displacement to the base to form the byte address. It reads that byte and reports the inverse of the selected bit on a zero-flag output. For set, clear and invert it then writes the byte back with only that bit changed. A test operation stops after the read.

The memory port uses a request/acknowledge handshake, and the acknowledge may come after any number of cycles. A lock output is held from the start of the read request until the write is acknowledged, so that no other access can fall between the two. The zero flag is the only status the block produces. It holds its value until the next read completes.

Top module: `mem_bit_rmw`

## Requirements
- R1: The read address equals base plus the displacement sign-extended to the address width, modulo 2^AW.
- R2: After an operation, zflag equals the logical inverse of the selected bit of the byte as it was read.
- R3: Operation code 2'b00 (set) writes the byte back with the selected bit at 1.
- R4: Operation code 2'b10 (clear) writes the byte back with the selected bit at 0.
- R5: Operation code 2'b01 (invert) writes the selected bit as the new zflag value, which is the inverse of the bit that was read.
- R6: Operation code 2'b11 (test) performs exactly one read and no write.
- R7: Every bit of the written byte other than the selected one equals the value that was read. Exactly one read precedes the single write.
- R8: mem_lock is high on every cycle in which mem_req is high, including the cycle between the read and the write. It is low once done has been seen.
- R9: done is high for exactly one cycle, in the cycle after the final acknowledge is taken.
- R10: A start while an operation is in progress is ignored: no extra access occurs and the running operation is unchanged.
- R11: zflag changes only when a read is acknowledged. It holds its value between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only when idle |
| op | input | 2 | 00 set, 01 invert, 10 clear, 11 test |
| bit_sel | input | 3 | Bit number within the byte |
| base | input | AW | Base address |
| disp | input | DISPW | Signed displacement |
| done | output | 1 | One-cycle completion pulse |
| zflag | output | 1 | Inverse of the selected bit as read |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | BYTEW | Write data |
| mem_rdata | input | BYTEW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_lock | output | 1 | Held across the read-modify-write |

## Verification
The read request rises two clock edges after start is taken: one edge latches the request and one computes the address. The write request follows on the edge after the read acknowledge. done and the new zflag become visible one edge after the final acknowledge. The bench drives inputs and a memory model with random acknowledge delays on falling edges. It polls done on falling edges, so every result is compared half a cycle after the edge that produced it. The single-cycle width of done and the hold of zflag are checked on the following falling edges.

// File: rtl/mem_bit_rmw.sv
module mem_bit_rmw #(
  parameter int AW    = 32,
  parameter int DISPW = 16,
  parameter int BYTEW = 8,
  localparam int SELW = $clog2(BYTEW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [SELW-1:0]  bit_sel,
  input  logic [AW-1:0]    base,
  input  logic [DISPW-1:0] disp,
  output logic             done,
  output logic             zflag,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [BYTEW-1:0] mem_wdata,
  input  logic [BYTEW-1:0] mem_rdata,
  input  logic             mem_ack,
  output logic             mem_lock
);

  localparam logic [1:0] OP_SET = 2'b00;
  localparam logic [1:0] OP_INV = 2'b01;
  localparam logic [1:0] OP_CLR = 2'b10;
  localparam logic [1:0] OP_TST = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RD, S_WR, S_DONE} state_t;

  state_t            st;
  logic [1:0]        op_q;
  logic [SELW-1:0]   sel_q;
  logic [AW-1:0]     base_q;
  logic [DISPW-1:0]  disp_q;
  logic [AW-1:0]     ea_q;
  logic [BYTEW-1:0]  wdata_q;
  logic              z_q;
  logic [BYTEW-1:0]  new_byte;

  wire [BYTEW-1:0] mask    = BYTEW'(1) << sel_q;
  wire             old_bit = |(mem_rdata & mask);
  wire [AW-1:0]    disp_x  = {{(AW-DISPW){disp_q[DISPW-1]}}, disp_q};

  always_comb begin
    case (op_q)
      OP_SET:  new_byte = mem_rdata | mask;
      OP_CLR:  new_byte = mem_rdata & ~mask;
      OP_INV:  new_byte = old_bit ? (mem_rdata & ~mask) : (mem_rdata | mask);
      default: new_byte = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_TST;
      sel_q   <= '0;
      base_q  <= '0;
      disp_q  <= '0;
      ea_q    <= '0;
      wdata_q <= '0;
      z_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          sel_q  <= bit_sel;
          base_q <= base;
          disp_q <= disp;
          st     <= S_ADDR;
        end
        S_ADDR: begin
          ea_q <= base_q + disp_x;
          st   <= S_RD;
        end
        S_RD: if (mem_ack) begin
          z_q     <= ~old_bit;
          wdata_q <= new_byte;
          st      <= (op_q == OP_TST) ? S_DONE : S_WR;
        end
        S_WR: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_lock  = mem_req;
  assign mem_addr  = ea_q;
  assign mem_wdata = wdata_q;
  assign done      = (st == S_DONE);
  assign zflag     = z_q;

endmodule

// File: rtl/mem_bit_rmw_chk.sv
module mem_bit_rmw_chk #(
  parameter int BYTEW = 8,
  localparam int SELW = $clog2(BYTEW)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             zflag,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic             mem_lock,
  input logic [BYTEW-1:0] mem_wdata,
  input logic [1:0]       op_q,
  input logic [SELW-1:0]  sel_q
);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_write_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_lock && $past(mem_lock)));

  assert_set_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && op_q == 2'b00) |-> mem_wdata[sel_q]);

  assert_clear_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && op_q == 2'b10) |-> !mem_wdata[sel_q]);

  assert_invert_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && op_q == 2'b01) |-> (mem_wdata[sel_q] == zflag));

  assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (op_q != 2'b11));

  assert_zflag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zflag) |-> $past(mem_req && mem_ack && !mem_we));

endmodule

bind mem_bit_rmw mem_bit_rmw_chk #(.BYTEW(BYTEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .zflag(zflag),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_lock(mem_lock), .mem_wdata(mem_wdata),
  .op_q(op_q), .sel_q(sel_q)
);

// File: tb/mem_bit_rmw_test.sv
module mem_bit_rmw_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [2:0]  bit_sel = '0;
  logic [31:0] base = '0;
  logic [15:0] disp = '0;
  logic        done, zflag, mem_req, mem_we, mem_lock;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  mem [logic [31:0]];
  int          rd_cnt = 0, wr_cnt = 0, lock_bad = 0;
  logic [31:0] last_rd_addr = '0;

  always #4 clk = ~clk;

  mem_bit_rmw uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_sel(bit_sel),
    .base(base), .disp(disp), .done(done), .zflag(zflag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_lock(mem_lock)
  );

  function automatic logic [7:0] mem_get(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_ea(input logic [31:0] b, input logic [15:0] d);
    return b + {{16{d[15]}}, d};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] old, input logic [1:0] o,
                                          input logic [2:0] s);
    logic [7:0] r = old;
    case (o)
      2'b00: r[s] = 1'b1;
      2'b10: r[s] = 1'b0;
      2'b01: r[s] = ~old[s];
      default: r = old;
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int ack_delay = 0;
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        if (!mem_lock) lock_bad++;
        if (cnt >= ack_delay) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem_get(mem_addr);
            last_rd_addr = mem_addr;
            rd_cnt++;
          end
        end else cnt++;
      end
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [2:0] s, input logic [31:0] b,
                        input logic [15:0] d, input bit poke);
    logic [31:0] ea = exp_ea(b, d);
    logic [7:0]  old = mem_get(ea);
    logic [7:0]  expb = exp_byte(old, o, s);
    logic [7:0]  got;
    logic        z_now;
    int r0 = rd_cnt, w0 = wr_cnt, n = 0;
    lock_bad = 0;
    @(negedge clk);
    start = 1'b1; op = o; bit_sel = s; base = b; disp = d;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      start = 1'b1; op = ~o; bit_sel = ~s; base = b ^ 32'h0000_0100; disp = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9 done seen", {31'd0, done}, 32'd1);
    chk(last_rd_addr == ea, "R1 read address", last_rd_addr, ea);
    chk(zflag == ~old[s], "R2 zflag", {31'd0, zflag}, {31'd0, ~old[s]});
    chk(rd_cnt == r0 + 1, "R7 one read", rd_cnt, r0 + 1);
    got = mem_get(ea);
    if (o == 2'b11) begin
      chk(wr_cnt == w0, "R6 test no write", wr_cnt, w0);
      chk(got == old, "R6 byte unchanged", {24'd0, got}, {24'd0, old});
    end else begin
      chk(wr_cnt == w0 + 1, "R7 one write", wr_cnt, w0 + 1);
      if (o == 2'b00) chk(got == expb, "R3 set byte", {24'd0, got}, {24'd0, expb});
      if (o == 2'b10) chk(got == expb, "R4 clear byte", {24'd0, got}, {24'd0, expb});
      if (o == 2'b01) begin
        chk(got == expb, "R5 invert byte", {24'd0, got}, {24'd0, expb});
        chk(got[s] == zflag, "R5 bit equals zflag", {31'd0, got[s]}, {31'd0, zflag});
      end
      chk(((got ^ old) & ~(8'd1 << s)) == 8'd0, "R7 other bits",
          {24'd0, got}, {24'd0, expb});
    end
    chk(lock_bad == 0, "R8 lock with req", lock_bad, 0);
    chk(mem_lock == 1'b0, "R8 lock low at done", {31'd0, mem_lock}, 32'd0);
    z_now = zflag;
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    chk(zflag == z_now, "R11 zflag holds", {31'd0, zflag}, {31'd0, z_now});
    if (poke) chk(rd_cnt == r0 + 1, "R10 start ignored", rd_cnt, r0 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_req == 1'b0 && mem_lock == 1'b0 && zflag == 1'b0,
        "R9 reset state", {28'd0, done, mem_req, mem_lock, zflag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ack_delay = 0;
    run_op(2'b00, 3'd7, 32'h0000_1000, 16'h8000, 1'b0);
    run_op(2'b10, 3'd0, 32'h0000_0010, 16'hFFF0, 1'b0);
    run_op(2'b01, 3'd3, 32'hFFFF_FFF0, 16'h0020, 1'b0);
    run_op(2'b01, 3'd3, 32'hFFFF_FFF0, 16'h0020, 1'b0);
    ack_delay = 2;
    run_op(2'b11, 3'd5, 32'h1234_5678, 16'h7FFF, 1'b0);
    run_op(2'b00, 3'd2, 32'h0000_2000, 16'h0004, 1'b1);
    run_op(2'b11, 3'd1, 32'h0000_2000, 16'h0004, 1'b1);
    for (int i = 0; i < 150; i++) begin
      ack_delay = $urandom_range(0, 3);
      run_op(2'($urandom), 3'($urandom), {24'h0, 8'($urandom)}, 16'($urandom_range(0, 15)) - 16'd8,
             ($urandom_range(0, 7) == 0));
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule